// File: doc/BRIEF.md
# 4×4 Block Matching Cost and Transform Unit

This unit compares two 4×4 blocks of 8-bit pixels and returns how much they differ after a Hadamard transform. It forms the per-pixel difference block, then runs a 4-point add/subtract butterfly over each row and then over each column. In cost mode it adds the absolute values of the 16 resulting coefficients and halves the total, which gives the matching cost a sub-pixel motion search uses. In transform mode it returns the 16 signed coefficients, so the same datapath can also do 4×4 transform work.

A new pair of blocks can be accepted on every clock cycle. Each result appears one cycle after its inputs are accepted. Interpolation of reference pixels and quantisation of coefficients are left to surrounding logic.

Top module: `satd4x4_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is 0, and `cost_out` and `coef_out` are all zeros.
- R2: Pixel (row r, column c), with r and c in 0..3, is the unsigned byte at bits [8*(4r+c)+7 : 8*(4r+c)] of `blk_a` and of `blk_b`. The difference taken is a − b.
- R3: The coefficient (u,v) is the sum over r and c of H(u,r)·H(v,c)·(a(r,c) − b(r,c)), where H(k,n) = −1 when the bit count of (k AND n) is odd and +1 otherwise. It is placed as a 13-bit two's-complement field at bits [13*(4u+v)+12 : 13*(4u+v)] of `coef_out`.
- R4: With `mode` = 0 (cost), `cost_out` is the sum of the absolute values of the 16 coefficients, shifted right by one, and `coef_out` is zero.
- R5: With `mode` = 1 (transform), `coef_out` carries the coefficients of R3 and `cost_out` is zero.
- R6: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high.
- R7: A cycle with `in_valid` low leaves `cost_out` and `coef_out` unchanged and gives `out_valid` = 0 in the next cycle.
- R8: When both blocks are equal, every coefficient and the cost are zero in either mode.
- R9: The extreme blocks reach full range without wrap: a = 255 and b = 0 everywhere gives coefficient (0,0) = 4080, all other coefficients 0, and a cost of 2040. Swapping the blocks gives −4080.
- R10: Operations issued on consecutive cycles, including ones that change mode from one cycle to the next, each produce their own result in consecutive output cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept the operands this cycle |
| mode | input | 1 | 0 = cost, 1 = transform coefficients |
| blk_a | input | 128 | Current block, 16 pixels in raster order |
| blk_b | input | 128 | Reference block, 16 pixels in raster order |
| out_valid | output | 1 | A result is presented this cycle |
| cost_out | output | 16 | Halved sum of absolute coefficients |
| coef_out | output | 208 | 16 signed coefficients, 13 bits each, raster order |

## Verification
Two things can happen in the same cycle here. The output register shows the result of one operation while it captures the next one, and that next operation may be in the other mode. The vector table is therefore run back to back with the mode alternating. Each cycle's outputs are compared with a matrix-form model of the transform, and the field of the mode that was not selected must read zero. Idle cycles between operations are then checked to confirm that the previous result stays unchanged while `out_valid` is low.

// File: rtl/satd_pkg.sv
package satd_pkg;
  typedef enum logic {
    MODE_COST  = 1'b0,
    MODE_XFORM = 1'b1
  } satd_mode_e;

  localparam int BLK_DIM = 4;
  localparam int BLK_PIX = BLK_DIM * BLK_DIM;
endpackage

// File: rtl/satd_diff.sv
// Per-pixel signed difference a - b over a whole block.
module satd_diff #(
  parameter int PIX_W = 8,
  parameter int NPIX  = 16,
  localparam int D_W  = PIX_W + 1
) (
  input  logic [NPIX*PIX_W-1:0] a,
  input  logic [NPIX*PIX_W-1:0] b,
  output logic [NPIX*D_W-1:0]   d
);
  function automatic logic [D_W-1:0] px_sub(input logic [PIX_W-1:0] x,
                                            input logic [PIX_W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  for (genvar i = 0; i < NPIX; i++) begin : g_px
    assign d[i*D_W +: D_W] = px_sub(a[i*PIX_W +: PIX_W], b[i*PIX_W +: PIX_W]);
  end
endmodule

// File: rtl/satd_hstage.sv
// One separable pass: a 4-point Hadamard butterfly on every row
// (ALONG_COLS = 0) or on every column (ALONG_COLS = 1).
module satd_hstage #(
  parameter int IN_W       = 9,
  parameter bit ALONG_COLS = 1'b0,
  localparam int OW        = IN_W + 2
) (
  input  logic [16*IN_W-1:0] x,
  output logic [16*OW-1:0]   y
);
  localparam int STRIDE = ALONG_COLS ? 4 : 1;

  // Natural-order butterfly; result element k sits at bits [k*OW +: OW].
  function automatic logic [4*OW-1:0] bfly4(input logic [IN_W-1:0] x0,
                                            input logic [IN_W-1:0] x1,
                                            input logic [IN_W-1:0] x2,
                                            input logic [IN_W-1:0] x3);
    logic signed [OW-1:0] p0, p1, m0, m1;
    p0 = OW'($signed(x0)) + OW'($signed(x2));
    p1 = OW'($signed(x1)) + OW'($signed(x3));
    m0 = OW'($signed(x0)) - OW'($signed(x2));
    m1 = OW'($signed(x1)) - OW'($signed(x3));
    return {m0 - m1, m0 + m1, p0 - p1, p0 + p1};
  endfunction

  for (genvar l = 0; l < 4; l++) begin : g_line
    localparam int BASE = ALONG_COLS ? l : 4 * l;
    logic [4*OW-1:0] res;
    assign res = bfly4(x[(BASE)*IN_W            +: IN_W],
                       x[(BASE + STRIDE)*IN_W   +: IN_W],
                       x[(BASE + 2*STRIDE)*IN_W +: IN_W],
                       x[(BASE + 3*STRIDE)*IN_W +: IN_W]);
    for (genvar k = 0; k < 4; k++) begin : g_el
      assign y[(BASE + k*STRIDE)*OW +: OW] = res[k*OW +: OW];
    end
  end
endmodule

// File: rtl/satd_abssum.sv
// Sum of magnitudes of the 16 coefficients.
module satd_abssum #(
  parameter int C_W = 13,
  localparam int S_W = C_W + 4
) (
  input  logic [16*C_W-1:0] c,
  output logic [S_W-1:0]    sum
);
  function automatic logic [S_W-1:0] mag(input logic [C_W-1:0] v);
    return v[C_W-1] ? S_W'(-$signed(v)) : S_W'(v);
  endfunction

  always_comb begin
    sum = '0;
    for (int i = 0; i < 16; i++) sum = sum + mag(c[i*C_W +: C_W]);
  end
endmodule

// File: rtl/satd4x4_unit.sv
module satd4x4_unit
  import satd_pkg::*;
#(
  parameter int PIX_W    = 8,
  localparam int D_W     = PIX_W + 1,
  localparam int T_W     = D_W + 2,
  localparam int C_W     = T_W + 2,
  localparam int S_W     = C_W + 4,
  localparam int COST_W  = S_W - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      mode,
  input  logic [BLK_PIX*PIX_W-1:0]  blk_a,
  input  logic [BLK_PIX*PIX_W-1:0]  blk_b,
  output logic                      out_valid,
  output logic [COST_W-1:0]         cost_out,
  output logic [BLK_PIX*C_W-1:0]    coef_out
);
  // Named internal stages, visible to the bound checker.
  logic [BLK_PIX*D_W-1:0] diff_blk;
  logic [BLK_PIX*T_W-1:0] row_blk;
  logic [BLK_PIX*C_W-1:0] coef_blk;
  logic [S_W-1:0]         abs_sum;
  logic                   take_cost;
  logic                   take_xform;

  satd_diff #(.PIX_W(PIX_W), .NPIX(BLK_PIX)) u_diff (
    .a(blk_a), .b(blk_b), .d(diff_blk)
  );

  satd_hstage #(.IN_W(D_W), .ALONG_COLS(1'b0)) u_rows (
    .x(diff_blk), .y(row_blk)
  );

  satd_hstage #(.IN_W(T_W), .ALONG_COLS(1'b1)) u_cols (
    .x(row_blk), .y(coef_blk)
  );

  satd_abssum #(.C_W(C_W)) u_sum (
    .c(coef_blk), .sum(abs_sum)
  );

  assign take_cost  = in_valid && (mode == MODE_COST);
  assign take_xform = in_valid && (mode == MODE_XFORM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cost_out  <= '0;
      coef_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (take_cost) begin
        cost_out <= abs_sum[S_W-1:1];
        coef_out <= '0;
      end else if (take_xform) begin
        cost_out <= '0;
        coef_out <= coef_blk;
      end
    end
  end
endmodule

// File: rtl/satd4x4_chk.sv
module satd4x4_chk #(
  parameter int PIX_W = 8,
  parameter int C_W   = 13,
  parameter int COST_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 mode,
  input logic [16*PIX_W-1:0]  blk_a,
  input logic [16*PIX_W-1:0]  blk_b,
  input logic                 out_valid,
  input logic [COST_W-1:0]    cost_out,
  input logic [16*C_W-1:0]    coef_out
);
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cost_out) && $stable(coef_out)));

  a_r4_cost_clears_coefs: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode) |=> (coef_out == '0));

  a_r5_xform_clears_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode) |=> (cost_out == '0));

  a_r8_equal_blocks_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (blk_a == blk_b)) |=> (cost_out == '0 && coef_out == '0));
endmodule

bind satd4x4_unit satd4x4_chk #(.PIX_W(PIX_W), .C_W(C_W), .COST_W(COST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
  .blk_a(blk_a), .blk_b(blk_b), .out_valid(out_valid),
  .cost_out(cost_out), .coef_out(coef_out)
);

// File: tb/satd4x4_unit_tb.sv
`timescale 1ns/1ps
module satd4x4_unit_tb;
  localparam int CW = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         mode = 1'b0;
  logic [127:0] blk_a = '0;
  logic [127:0] blk_b = '0;
  logic         out_valid;
  logic [15:0]  cost_out;
  logic [16*CW-1:0] coef_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  satd4x4_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .blk_a(blk_a), .blk_b(blk_b), .out_valid(out_valid),
    .cost_out(cost_out), .coef_out(coef_out)
  );

  // {mode, a, b}
  localparam logic [256:0] VEC [8] = '{
    {1'b0, 128'h00112233445566778899AABBCCDDEEFF, 128'hFFEEDDCCBBAA99887766554433221100},
    {1'b1, 128'h00112233445566778899AABBCCDDEEFF, 128'hFFEEDDCCBBAA99887766554433221100},
    {1'b0, 128'h0F0F0F0F0F0F0F0F0F0F0F0F0F0F0F0F, 128'hF0F0F0F0F0F0F0F0F0F0F0F0F0F0F0F0},
    {1'b1, 128'h123456789ABCDEF0FEDCBA9876543210, 128'h0123456789ABCDEF0123456789ABCDEF},
    {1'b0, 128'h80808080808080808080808080808080, 128'h7F7F7F7F7F7F7F7F7F7F7F7F7F7F7F7F},
    {1'b1, 128'hFF00FF00FF00FF0000FF00FF00FF00FF, 128'h00000000000000000000000000000000},
    {1'b0, 128'hDEADBEEFCAFEF00D0123456789ABCDEF, 128'h55AA55AA33CC33CC0F0FF0F011EE22DD},
    {1'b1, 128'h00000000000000000000000000000000, 128'h0123FFFF00FF7F80C0DE123498765432}
  };

  function automatic int px(input logic [127:0] blk, input int r, input int c);
    return int'(blk[8*(4*r+c) +: 8]);
  endfunction

  // Matrix form of the transform, entry by entry.
  function automatic int model_coef(input logic [127:0] a, input logic [127:0] b,
                                    input int u, input int v);
    int acc = 0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        int s = ((($countones(u & r) + $countones(v & c)) % 2) == 1) ? -1 : 1;
        acc += s * (px(a, r, c) - px(b, r, c));
      end
    return acc;
  endfunction

  function automatic int model_cost(input logic [127:0] a, input logic [127:0] b);
    int acc = 0;
    for (int i = 0; i < 16; i++) begin
      int k = model_coef(a, b, i / 4, i % 4);
      acc += (k < 0) ? -k : k;
    end
    return acc / 2;
  endfunction

  function automatic int got_coef(input int i);
    logic signed [CW-1:0] f;
    f = coef_out[CW*i +: CW];
    return int'(f);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_result(input string tag, input logic [127:0] a,
                              input logic [127:0] b, input logic m);
    int mism = 0;
    check({tag, " R6 valid"}, int'(out_valid), 1);
    if (m == 1'b0) begin
      check({tag, " R4 cost"}, int'(cost_out), model_cost(a, b));
      check({tag, " R4 coefs zero"}, int'(coef_out == '0), 1);
    end else begin
      for (int i = 0; i < 16; i++)
        if (got_coef(i) != model_coef(a, b, i / 4, i % 4)) begin
          if (mism == 0)
            check({tag, " R3 R5 coef"}, got_coef(i), model_coef(a, b, i / 4, i % 4));
          mism++;
        end
      if (mism == 0) check({tag, " R3 R5 coefs"}, 0, 0);
      check({tag, " R5 cost zero"}, int'(cost_out), 0);
    end
  endtask

  // Drive on the falling edge; the result is sampled one falling edge later.
  task automatic issue(input logic [127:0] a, input logic [127:0] b, input logic m);
    in_valid = 1'b1;
    mode     = m;
    blk_a    = a;
    blk_b    = b;
    @(negedge clk);
  endtask

  initial begin : watchdog
    for (int n = 0; n < 20000; n++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0]      keep_cost;
    logic [16*CW-1:0] keep_coef;

    // R1: reset state
    @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 cost in reset", int'(cost_out), 0);
    check("R1 coef in reset", int'(coef_out == '0), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", int'(out_valid), 0);

    // R10: table walked back to back with alternating modes
    for (int i = 0; i < 8; i++) begin
      issue(VEC[i][255:128], VEC[i][127:0], VEC[i][256]);
      check_result($sformatf("R10 vec%0d", i), VEC[i][255:128], VEC[i][127:0], VEC[i][256]);
    end

    // R7: idle cycles hold the last result
    in_valid = 1'b0;
    keep_cost = cost_out;
    keep_coef = coef_out;
    blk_a = '1;
    mode = 1'b0;
    @(negedge clk);
    check("R7 valid low", int'(out_valid), 0);
    @(negedge clk);
    check("R7 cost held", int'(cost_out), int'(keep_cost));
    check("R7 coef held", int'(coef_out == keep_coef), 1);

    // R2: single pixel (0,0) differing by 10 -> every coef +10, cost 80
    issue(128'h0A, 128'h0, 1'b1);
    check("R2 coef(3,3) from pixel(0,0)", got_coef(15), 10);
    issue(128'h0A, 128'h0, 1'b0);
    check("R2 cost pixel(0,0)", int'(cost_out), 80);

    // R2: pixel (3,3) differing by 1 -> coef(1,2) = H(1,3)H(2,3) = +1
    issue({8'h01, 120'h0}, 128'h0, 1'b1);
    check("R2 coef(1,2) from pixel(3,3)", got_coef(6), 1);
    check("R2 coef(0,1) from pixel(3,3)", got_coef(1), -1);

    // R9: full-range extremes
    issue('1, '0, 1'b1);
    check("R9 dc max", got_coef(0), 4080);
    check("R9 ac zero", got_coef(5), 0);
    issue('0, '1, 1'b1);
    check("R9 dc min", got_coef(0), -4080);
    issue('1, '0, 1'b0);
    check("R9 cost max", int'(cost_out), 2040);

    // R8: equal blocks, both modes
    issue(128'h5A5A1234ABCDEF0011223344556677FF, 128'h5A5A1234ABCDEF0011223344556677FF, 1'b0);
    check("R8 cost equal", int'(cost_out), 0);
    issue(128'h5A5A1234ABCDEF0011223344556677FF, 128'h5A5A1234ABCDEF0011223344556677FF, 1'b1);
    check("R8 coefs equal", int'(coef_out == '0), 1);

    // R1: reset mid-stream clears outputs
    issue('1, '0, 1'b0);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 cost after async reset", int'(cost_out), 0);
    check("R1 valid after async reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule